// File: doc/BRIEF.md
# Twisted-Pair Crossover Resolver

This block decides whether a twisted-pair port uses the straight pair assignment (MDI) or the crossed one (MDI-X). Its select output drives the external pair swap, which exchanges the transmit pair with the receive pair. The choice is settled before auto-negotiation is allowed to start. The `resolved` flag is the signal that tells the negotiation logic it may begin.

While hunting, the block holds the current assignment for a listening window of a set number of millisecond ticks and watches a detect input from the receive side. That input reports link pulses or 10BASE-T or 100BASE-TX data. If something is detected, the assignment is kept and the block locks. If the window runs out empty, an 11-bit pseudo-random shift register advances one step, and the bit it shifts in decides whether the assignment flips. While the port is sending link pulses, a busy input freezes the whole controller.

Top module: `mdix_resolver`

## Requirements
- R1: During reset, `mdix_sel` is 0 (0 = straight MDI, 1 = crossed MDI-X) and `resolved` is 0. The shift register is seeded with 11'h001.
- R2: While `enable` is low, `mdix_sel` is 0 and `resolved` is 0, and `ms_tick` has no effect. This holds even when `pulse_busy` is high. Listening starts one clock after `enable` is seen high.
- R3: While listening, `mdix_sel` holds for `WINDOW_MS` accepted ticks. The count starts on entry to listening or at the end of the previous window.
- R4: When a window ends, the register shifts left by one, taking bit10 XOR bit8 into bit0. If that new bit is 1, `mdix_sel` toggles on the same clock edge; if it is 0, `mdix_sel` keeps its value.
- R5: If `link_detect` is sampled high while listening, `resolved` is 1 after that edge and `mdix_sel` is kept. A detect that coincides with the final tick of a window wins, and the register does not step.
- R6: While locked with `link_detect` held high, `mdix_sel` and `resolved` do not change whatever `ms_tick` does.
- R7: When `link_detect` is sampled low while locked, the next edge clears `resolved`, sets `mdix_sel` to 0 and restarts the window. The register keeps its sequence and is not reseeded.
- R8: While `enable` and `pulse_busy` are both high, nothing changes. `mdix_sel`, `resolved`, the window count and the register all hold, ticks are not counted, and `link_detect` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the resolver; low forces the straight setting |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| link_detect | input | 1 | Receive side sees link pulses or data |
| pulse_busy | input | 1 | High while link pulses are being transmitted |
| mdix_sel | output | 1 | Pair select: 0 straight, 1 crossed |
| resolved | output | 1 | Assignment settled; auto-negotiation may start |

## Verification
The assertions assume that `ms_tick` is a single-cycle pulse. They also assume that a rise of `mdix_sel` can only happen on a clock where a tick was present with `enable` high and the block was not locked. The bench therefore always drives each tick for exactly one clock. It changes inputs just after the falling edge, so every input is stable at the sampling edge. Detect, busy and enable events are placed at chosen points inside a window: mid-window, on the final tick, and while locked. This lets the window count and the register sequence be predicted tick by tick.

// File: rtl/mdix_pkg.sv
// Package: shared types for the crossover resolver.
// Assumes: nothing beyond IEEE 1800-2017.
package mdix_pkg;

    // Controller phases: disabled, hunting within a window, settled.
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_LISTEN = 2'd1,
        ST_LOCKED = 2'd2
    } mdix_state_e;

endpackage

// File: rtl/mdix_lfsr.sv
// Module: mdix_lfsr
// Pseudo-random bit source. This is a Fibonacci shift register that moves
// one place left on each step and shifts in the XOR of two tap bits. The
// bit about to be shifted in is offered combinationally as the decision.
// Assumes: TAP_A and TAP_B lie within 1..W and SEED is nonzero.
module mdix_lfsr #(
    parameter int W            = 11,
    parameter int TAP_A        = 11,
    parameter int TAP_B        = 9,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic next_bit
);
    logic [W-1:0] q;

    // Feedback bit that the next step will shift in.
    always_comb next_bit = q[TAP_A-1] ^ q[TAP_B-1];

    // Reload the seed on reset; otherwise shift when stepped.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= SEED;
        else if (step) q <= {q[W-2:0], next_bit};
    end
endmodule

// File: rtl/mdix_window.sv
// Module: mdix_window
// Listening window timer. It counts accepted millisecond ticks and flags
// the tick that completes the window, then wraps to zero for the next one.
// Assumes: WINDOW_MS >= 2; advance is already qualified by the caller.
module mdix_window #(
    parameter int WINDOW_MS = 60,
    localparam int CNT_W    = (WINDOW_MS > 2) ? $clog2(WINDOW_MS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_MS - 1);

    logic [CNT_W-1:0] count;

    // The final accepted tick of the window.
    always_comb expire = advance && (count == LAST);

    // Count ticks; restart on clear or at window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  count <= '0;
        else if (expire)      count <= '0;
        else if (advance)     count <= count + 1'b1;
    end
endmodule

// File: rtl/mdix_ctrl_fsm.sv
// Module: mdix_ctrl_fsm
// Phase controller and pair-select register. Enable low overrides all
// inputs, busy freezes everything, detect locks, and loss of detect
// returns to hunting at the straight setting.
// Assumes: expire is only asserted while listening and not busy.
module mdix_ctrl_fsm
    import mdix_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        pulse_busy,
    input  logic        link_detect,
    input  logic        expire,
    input  logic        flip_bit,
    output mdix_state_e st,
    output logic        sel
);
    // Phase and select update, priority: reset, enable, busy, phase logic.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            st  <= ST_OFF;
            sel <= 1'b0;
        end else if (!pulse_busy) begin
            case (st)
                ST_OFF: begin
                    st  <= ST_LISTEN;
                    sel <= 1'b0;
                end
                ST_LISTEN: begin
                    if (link_detect)  st  <= ST_LOCKED;
                    else if (expire)  sel <= sel ^ flip_bit;
                end
                ST_LOCKED: begin
                    if (!link_detect) begin
                        st  <= ST_LISTEN;
                        sel <= 1'b0;
                    end
                end
                default: begin
                    st  <= ST_OFF;
                    sel <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mdix_resolver.sv
// Module: mdix_resolver (top)
// Chooses straight or crossed pair assignment before auto-negotiation.
// It ties the window timer, the pseudo-random source and the phase
// controller together.
// Assumes: ms_tick is a one-cycle pulse; all inputs are synchronous.
module mdix_resolver
    import mdix_pkg::*;
#(
    parameter int WINDOW_MS = 60,
    parameter int LFSR_W    = 11,
    parameter int TAP_A     = 11,
    parameter int TAP_B     = 9,
    parameter logic [LFSR_W-1:0] SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ms_tick,
    input  logic link_detect,
    input  logic pulse_busy,
    output logic mdix_sel,
    output logic resolved
);
    mdix_state_e st;
    logic        listening;
    logic        advance;
    logic        clear;
    logic        expire;
    logic        flip_bit;

    // Qualify ticks: only count while hunting, not frozen, nothing seen.
    always_comb begin
        listening = (st == ST_LISTEN);
        advance   = enable && !pulse_busy && listening && ms_tick && !link_detect;
        clear     = !enable || (!pulse_busy && !listening);
    end

    mdix_window #(.WINDOW_MS(WINDOW_MS)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .expire  (expire)
    );

    mdix_lfsr #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED(SEED)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (expire),
        .next_bit (flip_bit)
    );

    mdix_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .pulse_busy  (pulse_busy),
        .link_detect (link_detect),
        .expire      (expire),
        .flip_bit    (flip_bit),
        .st          (st),
        .sel         (mdix_sel)
    );

    // Settled flag straight from the registered phase.
    always_comb resolved = (st == ST_LOCKED);
endmodule

// File: rtl/mdix_resolver_chk.sv
// Module: mdix_resolver_chk
// Port-level temporal checks for mdix_resolver, attached by bind.
// Assumes: ms_tick pulses last one cycle.
module mdix_resolver_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic ms_tick,
    input logic link_detect,
    input logic pulse_busy,
    input logic mdix_sel,
    input logic resolved
);
    // R2
    off_forces_mdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!mdix_sel && !resolved));

    // R8
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pulse_busy) |=> ($stable(mdix_sel) && $stable(resolved)));

    // R6
    locked_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved && $past(resolved)) |-> $stable(mdix_sel));

    // R4
    sel_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdix_sel) |-> (!resolved && $past(ms_tick) && $past(enable)));

    // R5
    lock_needs_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resolved) |-> $past(link_detect));

    // R7
    loss_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved && !link_detect && !pulse_busy && enable) |=> (!resolved && !mdix_sel));
endmodule

bind mdix_resolver mdix_resolver_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .ms_tick     (ms_tick),
    .link_detect (link_detect),
    .pulse_busy  (pulse_busy),
    .mdix_sel    (mdix_sel),
    .resolved    (resolved)
);

// File: tb/sim_mdix_resolver.sv
module sim_mdix_resolver;
    localparam int CLK_NS = 10;
    localparam int W      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic ms_tick = 1'b0;
    logic link_detect = 1'b0;
    logic pulse_busy = 1'b0;
    logic mdix_sel;
    logic resolved;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    bit [10:0] mdl = 11'h001;
    bit exp_sel = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    mdix_resolver #(.WINDOW_MS(W)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ms_tick(ms_tick),
        .link_detect(link_detect), .pulse_busy(pulse_busy),
        .mdix_sel(mdix_sel), .resolved(resolved)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick_once();
        ms_tick = 1'b1;
        cyc();
        ms_tick = 1'b0;
    endtask

    task automatic model_expire();
        bit fb;
        fb  = mdl[10] ^ mdl[8];
        mdl = {mdl[9:0], fb};
        if (fb) exp_sel = ~exp_sel;
    endtask

    task automatic run_window();
        repeat (W-1) tick_once();
        check("R3 sel held inside window", mdix_sel, exp_sel);
        tick_once();
        model_expire();
        check("R4 sel after window end", mdix_sel, exp_sel);
        check("R3 not resolved while hunting", resolved, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        check("R1 reset sel", mdix_sel, 0);
        check("R1 reset resolved", resolved, 0);
        rst_n = 1'b1;
        pulse_busy = 1'b1;
        repeat (10) tick_once();
        pulse_busy = 1'b0;
        repeat (10) tick_once();
        check("R2 disabled sel", mdix_sel, 0);
        check("R2 disabled resolved", resolved, 0);

        // enable: one cycle to begin listening, then window sweep
        enable = 1'b1;
        cyc();
        for (int k = 0; k < 30; k++) run_window();

        // R8: busy freezes the count, detect ignored
        tick_once(); tick_once();
        pulse_busy = 1'b1;
        repeat (5) tick_once();
        link_detect = 1'b1; cyc(); link_detect = 1'b0;
        check("R8 sel frozen by busy", mdix_sel, exp_sel);
        check("R8 detect ignored while busy", resolved, 0);
        pulse_busy = 1'b0;
        repeat (W-3) tick_once();
        check("R8 busy ticks not counted", mdix_sel, exp_sel);
        tick_once();
        model_expire();
        check("R8 window resumes after busy", mdix_sel, exp_sel);

        // R5: detect coincides with final tick
        repeat (W-1) tick_once();
        link_detect = 1'b1; ms_tick = 1'b1;
        cyc();
        ms_tick = 1'b0;
        check("R5 resolved after detect", resolved, 1);
        check("R5 sel kept on lock", mdix_sel, exp_sel);
        repeat (10) tick_once();
        check("R6 locked sel stable", mdix_sel, exp_sel);
        check("R6 locked stays resolved", resolved, 1);
        link_detect = 1'b0;
        cyc();
        exp_sel = 1'b0;
        check("R7 loss clears resolved", resolved, 0);
        check("R7 loss returns to MDI", mdix_sel, 0);
        for (int k = 0; k < 12; k++) run_window();

        // R8 in locked phase
        tick_once();
        link_detect = 1'b1; cyc();
        check("R5 relock", resolved, 1);
        pulse_busy = 1'b1; link_detect = 1'b0;
        repeat (3) cyc();
        check("R8 busy holds lock after loss", resolved, 1);
        pulse_busy = 1'b0;
        cyc();
        exp_sel = 1'b0;
        check("R7 unlock after busy ends", resolved, 0);

        // R2: enable low overrides busy while locked
        link_detect = 1'b1; cyc();
        check("R5 lock before disable", resolved, 1);
        pulse_busy = 1'b1; enable = 1'b0;
        cyc();
        check("R2 disable clears resolved despite busy", resolved, 0);
        check("R2 disable sets MDI", mdix_sel, 0);
        pulse_busy = 1'b0; link_detect = 1'b0;
        enable = 1'b1;
        cyc();
        run_window();
        run_window();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule